// File: doc/BRIEF.md
# Crystal oscillator frequency watchdog

This block watches an external oscillator clock from the side of a slow, free-running local reference clock of about 1 MHz. It counts the oscillator's rising edges over a fixed window of reference cycles and compares each count with a programmable low and high bound. A count above the high bound points to the crystal running on a harmonic. A count below the low bound points to a sub-harmonic. A separate timer flags an oscillator that has stopped toggling altogether.

The edge count is made in the oscillator's own domain. At each window boundary it is captured into a holding register and announced to the reference domain with a toggle handshake. The reference domain compares the count with the bounds, updates three sticky status bits, and drives a fault flag, a maskable fault pin and a clock-not-good output. One control word holds the bounds, an enable for each check, a fault enable, a pin mask and a global monitor disable. A lock bit makes that word read-only until the next reset.

Top module: `osc_watchdog`

## Requirements
- R1: After reset, `ctrl_q` reads 32'h0040_0000 (only the monitor-disable bit 22 set), `status_q` is 0, and `fault_flag`, `fault_pin` and `clk_bad` are 0.
- R2: With every check enabled and an oscillator whose window count lies between the low bound `ctrl_q[7:0]` and the high bound `ctrl_q[15:8]`, no status bit is set.
- R3: When high-check enable bit 17 is set and a window count exceeds the high bound, status bit 1 (over-frequency) is set.
- R4: When low-check enable bit 18 is set and a window count is below the low bound, status bit 0 is left alone and status bit 2 (under-frequency) is set.
- R5: When stop-check enable bit 16 is set and no count arrives from the oscillator domain for `STOP_LIM` reference cycles, status bit 0 (no clock) is set.
- R6: A check whose enable bit is clear never sets its status bit, whatever the oscillator does.
- R7: `fault_flag` is 1 while fault-enable bit 20 is set, monitoring is on and any status bit is set. `clk_bad` follows the same rule, using the clock-not-good enable bit 19 in place of bit 20.
- R8: Status bits stay set after the condition ends. A write with `reg_sel`=1 clears each status bit whose `reg_wdata` bit is 1.
- R9: While monitor-disable bit 22 is set, no status bit becomes set, and `fault_flag`, `fault_pin` and `clk_bad` are 0.
- R10: When pin-mask bit 21 is set, `fault_pin` is 0 even while `fault_flag` is 1. When bit 21 is clear, `fault_pin` equals `fault_flag`.
- R11: A control write (`reg_sel`=0) stores bits 31, 22:16 and 15:0, and bits 30:23 read 0. Once lock bit 31 reads 1, later control writes leave `ctrl_q` unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock, about 1 MHz |
| osc_clk | input | 1 | Monitored oscillator clock; may stop |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| reg_wr_en | input | 1 | Register write strobe, reference domain |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status clear |
| reg_wdata | input | 32 | Write data |
| ctrl_q | output | 32 | Current control word |
| status_q | output | 3 | Sticky status: bit 0 no clock, bit 1 over-frequency, bit 2 under-frequency |
| fault_flag | output | 1 | Internal fault indication |
| fault_pin | output | 1 | External fault output after masking |
| clk_bad | output | 1 | Clock-not-good indication |

## Verification
The assertions assume the oscillator clock changes period only at a rate that lets the count held for each window stay stable until the reference domain has captured it. This holds whenever a window lasts many reference cycles longer than the synchroniser delay. They also assume that register writes are single-cycle strobes in the reference domain. The bench changes the oscillator period only between waits of several whole windows. It switches between exact integer ratios (nominal, doubled, halved, stopped), and it drives every write one cycle wide, away from the reference edge. Status is cleared only after the measurement has settled, so that a window straddling a frequency change is never the one being judged.

// File: rtl/osc_wd_pkg.sv
`timescale 1ns/1ps
package osc_wd_pkg;
  // status bit positions
  localparam int ST_STOP = 0;
  localparam int ST_HIGH = 1;
  localparam int ST_LOW  = 2;
  localparam int NUM_ST  = 3;

  // offsets of flag bits above the two limit fields
  localparam int OFS_STOP_EN  = 0;
  localparam int OFS_HIGH_EN  = 1;
  localparam int OFS_LOW_EN   = 2;
  localparam int OFS_CNG_EN   = 3;
  localparam int OFS_FAULT_EN = 4;
  localparam int OFS_PIN_DIS  = 5;
  localparam int OFS_MON_DIS  = 6;
  localparam int LOCK_BIT     = 31;

  typedef struct packed {
    logic lock;
    logic mon_dis;
    logic pin_dis;
    logic fault_en;
    logic cng_en;
    logic low_en;
    logic high_en;
    logic stop_en;
  } wd_flags_t;
endpackage

// File: rtl/osc_wd_bit_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with asynchronous clear. With d tied high it
// serves as a reset synchroniser (async assert, sync release).
module osc_wd_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/osc_wd_edge_counter.sv
`timescale 1ns/1ps
// Oscillator-domain edge counter. A toggle from the reference domain marks
// window boundaries; at each boundary the count is parked in hold_cnt and
// ack_tgl flips to announce it.
module osc_wd_edge_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic             win_tgl_in,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             ack_tgl
);
  logic             win_s;
  logic             win_prev_q;
  logic             win_evt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             ack_q, ack_d;

  osc_wd_bit_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
    .clk(osc_clk), .rst_n(osc_rst_n), .d(win_tgl_in), .q(win_s)
  );

  assign win_evt = win_s ^ win_prev_q;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    ack_d  = ack_q;
    if (win_evt) begin
      hold_d = cnt_q;
      cnt_d  = CNT_W'(1);
      ack_d  = ~ack_q;
    end else if (cnt_q != '1) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      win_prev_q <= 1'b0;
      cnt_q      <= '0;
      hold_q     <= '0;
      ack_q      <= 1'b0;
    end else begin
      win_prev_q <= win_s;
      cnt_q      <= cnt_d;
      hold_q     <= hold_d;
      ack_q      <= ack_d;
    end
  end

  assign hold_cnt = hold_q;
  assign ack_tgl  = ack_q;
endmodule

// File: rtl/osc_wd_regs.sv
`timescale 1ns/1ps
// Control word, limit comparison and sticky status, reference domain.
module osc_wd_regs
  import osc_wd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wdata,
  input  logic              smp_vld,
  input  logic [CNT_W-1:0]  smp_cnt,
  input  logic              stop_hit,
  output logic [31:0]       ctrl_q,
  output logic [NUM_ST-1:0] status_q,
  output logic              fault_flag,
  output logic              fault_pin,
  output logic              clk_bad
);
  localparam int FB    = 2 * CNT_W;
  localparam int PAD_W = 24 - FB;

  logic [CNT_W-1:0]  lo_q, lo_d, hi_q, hi_d;
  wd_flags_t         flg_q, flg_d;
  logic [NUM_ST-1:0] st_q, st_d, st_set, st_clr;
  logic              mon_on, any_st;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[30:FB+7];

  // control word next state; lock blocks every control write
  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    flg_d = flg_q;
    if (wr_en && !wr_sel && !flg_q.lock) begin
      lo_d       = wdata[CNT_W-1:0];
      hi_d       = wdata[FB-1:CNT_W];
      flg_d      = wd_flags_t'({wdata[LOCK_BIT], wdata[FB+OFS_MON_DIS:FB]});
    end
  end

  assign mon_on = !flg_q.mon_dis;

  // status next state: set wins over write-one-to-clear
  always_comb begin
    st_set          = '0;
    st_set[ST_STOP] = stop_hit && flg_q.stop_en;
    st_set[ST_HIGH] = smp_vld && (smp_cnt > hi_q) && flg_q.high_en;
    st_set[ST_LOW]  = smp_vld && (smp_cnt < lo_q) && flg_q.low_en;
    if (!mon_on) st_set = '0;
    st_clr = (wr_en && wr_sel) ? wdata[NUM_ST-1:0] : '0;
    st_d   = (st_q & ~st_clr) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      flg_q <= '{mon_dis: 1'b1, default: 1'b0};
      st_q  <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      flg_q <= flg_d;
      st_q  <= st_d;
    end
  end

  assign any_st     = |st_q;
  assign fault_flag = mon_on && flg_q.fault_en && any_st;
  assign fault_pin  = fault_flag && !flg_q.pin_dis;
  assign clk_bad    = mon_on && flg_q.cng_en && any_st;
  assign status_q   = st_q;
  assign ctrl_q     = {flg_q.lock, {PAD_W{1'b0}}, flg_q[6:0], hi_q, lo_q};
endmodule

// File: rtl/osc_watchdog.sv
`timescale 1ns/1ps
module osc_watchdog
  import osc_wd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WIN_CYC     = 16,
  parameter int STOP_LIM    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       ctrl_q,
  output logic [NUM_ST-1:0] status_q,
  output logic              fault_flag,
  output logic              fault_pin,
  output logic              clk_bad
);
  localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int STOP_W = $clog2(STOP_LIM + 1);

  logic             ref_rst_n, osc_rst_n;
  logic [WIN_W-1:0] win_cnt_q, win_cnt_d;
  logic             win_tgl_q, win_tgl_d;
  logic [CNT_W-1:0] hold_cnt;
  logic             ack_tgl, ack_s, ack_prev_q, ack_evt;
  logic [CNT_W-1:0] smp_q, smp_d;
  logic             smp_vld_q;
  logic [STOP_W-1:0] idle_q, idle_d;
  logic             stop_hit;

  osc_wd_bit_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );
  osc_wd_bit_sync #(.STAGES(SYNC_STAGES)) u_osc_rst (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n)
  );

  osc_wd_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_edge_cnt (
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .win_tgl_in(win_tgl_q),
    .hold_cnt(hold_cnt), .ack_tgl(ack_tgl)
  );

  osc_wd_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign ack_evt  = ack_s ^ ack_prev_q;
  assign stop_hit = (idle_q == STOP_W'(STOP_LIM));

  always_comb begin
    win_cnt_d = win_cnt_q + WIN_W'(1);
    win_tgl_d = win_tgl_q;
    if (win_cnt_q == WIN_W'(WIN_CYC - 1)) begin
      win_cnt_d = '0;
      win_tgl_d = ~win_tgl_q;
    end
    // hold_cnt is stable for a whole window after its toggle arrives
    smp_d  = ack_evt ? hold_cnt : smp_q;
    idle_d = idle_q;
    if (ack_evt)             idle_d = '0;
    else if (!stop_hit)      idle_d = idle_q + STOP_W'(1);
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      win_cnt_q  <= '0;
      win_tgl_q  <= 1'b0;
      ack_prev_q <= 1'b0;
      smp_q      <= '0;
      smp_vld_q  <= 1'b0;
      idle_q     <= '0;
    end else begin
      win_cnt_q  <= win_cnt_d;
      win_tgl_q  <= win_tgl_d;
      ack_prev_q <= ack_s;
      smp_q      <= smp_d;
      smp_vld_q  <= ack_evt;
      idle_q     <= idle_d;
    end
  end

  osc_wd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(ref_clk), .rst_n(ref_rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_sel), .wdata(reg_wdata),
    .smp_vld(smp_vld_q), .smp_cnt(smp_q), .stop_hit(stop_hit),
    .ctrl_q(ctrl_q), .status_q(status_q),
    .fault_flag(fault_flag), .fault_pin(fault_pin), .clk_bad(clk_bad)
  );
endmodule

// File: rtl/osc_wd_checker.sv
`timescale 1ns/1ps
module osc_wd_checker
  import osc_wd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_sel,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       ctrl_q,
  input logic [NUM_ST-1:0] status_q,
  input logic              fault_flag,
  input logic              fault_pin,
  input logic              clk_bad
);
  localparam int FB = 2 * CNT_W;

  logic [NUM_ST-1:0] clr_mask;
  assign clr_mask = (reg_wr_en && reg_sel) ? reg_wdata[NUM_ST-1:0] : '0;

  // R11: a locked control word never changes
  p_lock_freeze_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ctrl_q[LOCK_BIT] |=> $stable(ctrl_q));

  // R8: set bits stay set unless a clear write names them
  p_sticky_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (status_q != '0) |=>
      ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

  // R9: no status bit rises while monitoring is disabled
  p_mondis_quiet_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ctrl_q[FB+OFS_MON_DIS] |=> ((status_q & ~$past(status_q)) == '0));

  // R9: outputs stay low while monitoring is disabled
  p_mondis_out_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ctrl_q[FB+OFS_MON_DIS] |-> (!fault_flag && !clk_bad));

  // R6: a disabled over-frequency check never raises its bit
  p_gate_high_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ctrl_q[FB+OFS_HIGH_EN] |=> !$rose(status_q[ST_HIGH]));

  // R10: the pin never shows a fault the internal flag lacks
  p_pin_flag_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fault_pin |-> fault_flag);

  // R7: fault flag needs a recorded status bit
  p_fault_src_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fault_flag || clk_bad) |-> (status_q != '0));
endmodule

bind osc_watchdog osc_wd_checker #(.CNT_W(CNT_W)) u_osc_wd_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ctrl_q(ctrl_q), .status_q(status_q),
  .fault_flag(fault_flag), .fault_pin(fault_pin), .clk_bad(clk_bad)
);

// File: tb/osc_watchdog_bench.sv
`timescale 1ns/1ps
module osc_watchdog_bench;
  localparam int REF_PERIOD = 80;
  localparam int NOM_HALF   = 10;   // 64 edges per 16-cycle window
  localparam int SETTLE     = 64;   // four windows
  localparam logic [31:0] CFG_ALL = 32'h001F_6030; // lo=48 hi=96, bits 20:16 set

  logic        ref_clk, osc_clk, rst_n;
  logic        reg_wr_en, reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] ctrl_q;
  logic [2:0]  status_q;
  logic        fault_flag, fault_pin, clk_bad;

  int checks = 0;
  int errors = 0;
  int osc_half = NOM_HALF;
  bit done = 0;

  osc_watchdog u_osc_watchdog (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .status_q(status_q),
    .fault_flag(fault_flag), .fault_pin(fault_pin), .clk_bad(clk_bad)
  );

  initial begin
    ref_clk = 1'b0;
    forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
  end

  initial begin
    osc_clk = 1'b0;
    forever begin
      if (osc_half == 0) begin
        osc_clk = 1'b0;
        #(REF_PERIOD);
      end else begin
        #(osc_half) osc_clk = ~osc_clk;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge ref_clk);
    reg_wr_en = 1'b1;
    reg_sel   = sel;
    reg_wdata = data;
    @(negedge ref_clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic settle_clear();
    wait_ref(SETTLE);
    wr(1'b1, 32'h7);
    wait_ref(SETTLE);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    wait_ref(4);
    rst_n = 1'b1;
    wait_ref(4);
    check(ctrl_q == 32'h0040_0000, "R1 ctrl", ctrl_q, 32'h0040_0000);
    check(status_q == 3'b000, "R1 status", 32'(status_q), 32'h0);
    check({fault_flag, fault_pin, clk_bad} == 3'b000, "R1 outputs",
          32'({fault_flag, fault_pin, clk_bad}), 32'h0);
  endtask

  task automatic t_nominal();
    wr(1'b0, CFG_ALL);
    check(ctrl_q == CFG_ALL, "R11 ctrl store", ctrl_q, CFG_ALL);
    settle_clear();
    check(status_q == 3'b000, "R2 nominal quiet", 32'(status_q), 32'h0);
  endtask

  task automatic t_high();
    osc_half = NOM_HALF / 2;
    wait_ref(SETTLE);
    check(status_q[1] == 1'b1, "R3 over-frequency", 32'(status_q), 32'h2);
    check(fault_flag && fault_pin && clk_bad, "R7 outputs on fault",
          32'({fault_flag, fault_pin, clk_bad}), 32'h7);
    osc_half = NOM_HALF;
    wait_ref(SETTLE);
    check(status_q[1] == 1'b1, "R8 sticky", 32'(status_q), 32'h2);
    wr(1'b1, 32'h2);
    check(status_q[1] == 1'b0, "R8 write-one clear", 32'(status_q), 32'h0);
    settle_clear();
  endtask

  task automatic t_low();
    osc_half = NOM_HALF * 2;
    wait_ref(SETTLE);
    check(status_q[2:1] == 2'b10, "R4 under-frequency", 32'(status_q), 32'h4);
    check(status_q[0] == 1'b0, "R4 not a stop", 32'(status_q), 32'h4);
    osc_half = NOM_HALF;
    settle_clear();
  endtask

  task automatic t_stop();
    osc_half = 0;
    wait_ref(SETTLE);
    check(status_q[0] == 1'b1, "R5 no clock", 32'(status_q), 32'h1);
    osc_half = NOM_HALF;
    settle_clear();
    check(status_q == 3'b000, "R5 recovered", 32'(status_q), 32'h0);
  endtask

  task automatic t_enable_gate();
    wr(1'b0, CFG_ALL & ~32'h0002_0000);
    wr(1'b1, 32'h7);
    osc_half = NOM_HALF / 2;
    wait_ref(SETTLE);
    check(status_q == 3'b000, "R6 high check disabled", 32'(status_q), 32'h0);
    check(fault_flag == 1'b0, "R6 no fault", 32'(fault_flag), 32'h0);
    osc_half = NOM_HALF;
    wait_ref(SETTLE);
  endtask

  task automatic t_mondis();
    wr(1'b0, CFG_ALL | 32'h0040_0000);
    wr(1'b1, 32'h7);
    osc_half = NOM_HALF / 2;
    wait_ref(SETTLE);
    check(status_q == 3'b000, "R9 monitor off status", 32'(status_q), 32'h0);
    check({fault_flag, fault_pin, clk_bad} == 3'b000, "R9 monitor off outputs",
          32'({fault_flag, fault_pin, clk_bad}), 32'h0);
    osc_half = NOM_HALF;
    wr(1'b0, CFG_ALL);
    settle_clear();
  endtask

  task automatic t_pin_mask();
    wr(1'b0, CFG_ALL | 32'h0020_0000);
    wr(1'b1, 32'h7);
    osc_half = NOM_HALF / 2;
    wait_ref(SETTLE);
    check(fault_flag == 1'b1, "R10 internal flag", 32'(fault_flag), 32'h1);
    check(fault_pin == 1'b0, "R10 pin masked", 32'(fault_pin), 32'h0);
    osc_half = NOM_HALF;
    settle_clear();
  endtask

  task automatic t_lock();
    wr(1'b0, CFG_ALL | 32'hFF80_0000);
    check(ctrl_q == (CFG_ALL | 32'h8000_0000), "R11 lock stored", ctrl_q,
          CFG_ALL | 32'h8000_0000);
    wr(1'b0, 32'h0040_0000);
    check(ctrl_q == (CFG_ALL | 32'h8000_0000), "R11 locked write ignored", ctrl_q,
          CFG_ALL | 32'h8000_0000);
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_high();
    t_low();
    t_stop();
    t_enable_gate();
    t_mondis();
    t_pin_mask();
    t_lock();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule